// File: doc/BRIEF.md
# Pipelined Two-Slice Unsigned Squarer

This block squares an unsigned operand of up to 33 bits and returns the exact result. It needs three slice-sized multiplies instead of the four a general two-slice multiplier would use. The operand is cut into a 17-bit low slice and an upper slice. The two symmetric cross products are the same value, so they are formed only once. To double that shared cross product, the upper slice is shifted left by one bit before it enters its multiplier. Because of this, the three partial products sit at offsets of 0, 17 and 34 bits. They are summed with shifts that are all multiples of the slice width, with no 18-bit offset and no subtract stage.

A caller presents one operand per cycle with a valid flag. Three register stages later the square appears with its own valid flag:

1. Slice capture.
2. Partial products.
3. Recombination.

Operands can be issued on every cycle. While no result is being delivered, the result port keeps its last value.

Top module: `dual_slice_squarer`

## Requirements
- R1: The operand is split so that its bits 16..0 form the low slice and its bits 32..17 form the upper slice. An operand with only the low slice non-zero, or only the upper slice non-zero, is squared exactly.
- R2: For every valid operand X, `sq_out` equals X*X over its full 66-bit width, with no truncation or rounding.
- R3: An operand sampled with `op_valid` high at rising edge t produces `sq_valid` high after rising edge t+2, which is the third register stage. `sq_valid` is low in every cycle that carries no result.
- R4: Valid operands on consecutive cycles produce results on consecutive cycles, in issue order.
- R5: Operands presented with `op_valid` low have no effect. While `sq_valid` is low, `sq_out` holds the last delivered square.
- R6: Synchronous active-high reset drives `sq_valid` and `sq_out` to zero and discards operands in flight.
- R7: The extreme operands are squared exactly:
  - zero gives zero;
  - all-ones gives (2^33-1)^2;
  - only bit 32 set gives 2^64.
- R8: The cross product is formed from the pre-doubled upper slice, so it is always even, and it is added at an offset of 17 bits. An operand of 2^17+1 yields 2^34 + 2^18 + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand qualifier |
| op_x | input | 33 | Unsigned operand (OP_W) |
| sq_valid | output | 1 | Result qualifier |
| sq_out | output | 66 | Unsigned square (2*OP_W) |

## Verification
The bench builds the block with its default values: a 33-bit operand and a 17-bit slice. This is the widest setting at which the doubled upper slice (17 bits) still fits an 18-bit multiplier input, so the bench reaches the following cases:
- carries out of the shared cross product into the upper slice's square;
- the bit-18 contribution that the pre-doubling moves;
- the full 66-bit result range.

Random operands are mixed with idle gaps and a reset while operands are in flight, so the stream also exercises the hold behaviour and the discarding of operands during reset.

// File: rtl/dss_pkg.sv
package dss_pkg;

    localparam int unsigned SLICE_W_DEF = 17;
    localparam int unsigned OP_W_DEF    = 33;

    // Partial product kinds; the enum value is the slice multiple of its offset.
    typedef enum logic [1:0] {
        TERM_LOW   = 2'd0,
        TERM_CROSS = 2'd1,
        TERM_HIGH  = 2'd2
    } term_e;

    function automatic int unsigned term_shift(term_e t, int unsigned slice_w);
        return slice_w * int'(t);
    endfunction

    function automatic int unsigned upper_width(int unsigned op_w, int unsigned slice_w);
        return op_w - slice_w;
    endfunction

endpackage

// File: rtl/dss_split.sv
module dss_split
    import dss_pkg::*;
#(
    parameter int unsigned OP_W    = OP_W_DEF,
    parameter int unsigned SLICE_W = SLICE_W_DEF,
    localparam int unsigned HI_W   = upper_width(OP_W, SLICE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [OP_W-1:0]    in_x,
    output logic               s1_vld,
    output logic [SLICE_W-1:0] lo_q,
    output logic [HI_W-1:0]    hi_q,
    output logic [HI_W:0]      hi_dbl_q
);

    logic [SLICE_W-1:0] lo_d;
    logic [HI_W-1:0]    hi_d;

    always_comb begin
        lo_d = in_x[SLICE_W-1:0];
        hi_d = in_x[OP_W-1:SLICE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            hi_dbl_q <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                lo_q     <= lo_d;
                hi_q     <= hi_d;
                // doubling applied ahead of the multiplier input
                hi_dbl_q <= {hi_d, 1'b0};
            end
        end
    end

endmodule

// File: rtl/dss_mul.sv
module dss_mul #(
    parameter int unsigned A_W = 17,
    parameter int unsigned B_W = 17,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);

    logic [P_W-1:0] prod;

    always_comb prod = P_W'(a) * P_W'(b);

    always_ff @(posedge clk) begin
        if (rst)     p <= '0;
        else if (en) p <= prod;
    end

endmodule

// File: rtl/dss_combine.sv
module dss_combine
    import dss_pkg::*;
#(
    parameter int unsigned OP_W    = OP_W_DEF,
    parameter int unsigned SLICE_W = SLICE_W_DEF,
    localparam int unsigned HI_W   = upper_width(OP_W, SLICE_W),
    localparam int unsigned LO_PW  = 2 * SLICE_W,
    localparam int unsigned CR_PW  = HI_W + 1 + SLICE_W,
    localparam int unsigned HI_PW  = 2 * HI_W,
    localparam int unsigned OUT_W  = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LO_PW-1:0] p_lo,
    input  logic [CR_PW-1:0] p_cross,
    input  logic [HI_PW-1:0] p_hi,
    output logic             o_vld,
    output logic [OUT_W-1:0] o_sq
);

    localparam int unsigned SH_CROSS = term_shift(TERM_CROSS, SLICE_W);
    localparam int unsigned SH_HIGH  = term_shift(TERM_HIGH, SLICE_W);

    logic [OUT_W-1:0] sum;

    always_comb begin
        sum = OUT_W'(p_lo)
            + (OUT_W'(p_cross) << SH_CROSS)
            + (OUT_W'(p_hi)    << SH_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
            o_sq  <= '0;
        end else begin
            o_vld <= en;
            if (en) o_sq <= sum;
        end
    end

endmodule

// File: rtl/dual_slice_squarer.sv
module dual_slice_squarer
    import dss_pkg::*;
#(
    parameter int unsigned OP_W    = OP_W_DEF,
    parameter int unsigned SLICE_W = SLICE_W_DEF,
    localparam int unsigned HI_W   = upper_width(OP_W, SLICE_W),
    localparam int unsigned OUT_W  = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_x,
    output logic             sq_valid,
    output logic [OUT_W-1:0] sq_out
);

    logic               s1_vld;
    logic               s2_vld;
    logic [SLICE_W-1:0] lo_q;
    logic [HI_W-1:0]    hi_q;
    logic [HI_W:0]      hi_dbl_q;

    logic [2*SLICE_W-1:0]      p_lo;
    logic [HI_W+1+SLICE_W-1:0] p_cross;
    logic [2*HI_W-1:0]         p_hi;

    dss_split #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_split (
        .clk(clk), .rst(rst), .in_vld(op_valid), .in_x(op_x),
        .s1_vld(s1_vld), .lo_q(lo_q), .hi_q(hi_q), .hi_dbl_q(hi_dbl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) s2_vld <= 1'b0;
        else     s2_vld <= s1_vld;
    end

    dss_mul #(.A_W(SLICE_W), .B_W(SLICE_W)) u_mul_lo (
        .clk(clk), .rst(rst), .en(s1_vld), .a(lo_q), .b(lo_q), .p(p_lo)
    );

    dss_mul #(.A_W(HI_W + 1), .B_W(SLICE_W)) u_mul_cross (
        .clk(clk), .rst(rst), .en(s1_vld), .a(hi_dbl_q), .b(lo_q), .p(p_cross)
    );

    dss_mul #(.A_W(HI_W), .B_W(HI_W)) u_mul_hi (
        .clk(clk), .rst(rst), .en(s1_vld), .a(hi_q), .b(hi_q), .p(p_hi)
    );

    dss_combine #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_comb (
        .clk(clk), .rst(rst), .en(s2_vld),
        .p_lo(p_lo), .p_cross(p_cross), .p_hi(p_hi),
        .o_vld(sq_valid), .o_sq(sq_out)
    );

endmodule

// File: rtl/dss_chk.sv
module dss_chk #(
    parameter int unsigned OP_W = 33,
    localparam int unsigned OUT_W = 2 * OP_W
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_x,
    input logic             sq_valid,
    input logic [OUT_W-1:0] sq_out,
    input logic             mid_vld,
    input logic             cross_lsb
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (sq_valid == $past(op_valid, 3)));

    // R2
    exact_square_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && sq_valid) |->
            (sq_out == OUT_W'($past(op_x, 3)) * OUT_W'($past(op_x, 3))));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !sq_valid) |-> $stable(sq_out));

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sq_valid && sq_out == '0));

    // R8
    cross_even_chk: assert property (@(posedge clk) disable iff (rst)
        mid_vld |-> !cross_lsb);

endmodule

bind dual_slice_squarer dss_chk #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_x(op_x),
    .sq_valid(sq_valid), .sq_out(sq_out),
    .mid_vld(s2_vld), .cross_lsb(p_cross[0])
);

// File: tb/dual_slice_squarer_tb.sv
module dual_slice_squarer_tb;

    localparam int OP_W  = 33;
    localparam int OUT_W = 66;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic             op_valid;
    logic [OP_W-1:0]  op_x;
    logic             sq_valid;
    logic [OUT_W-1:0] sq_out;

    dual_slice_squarer u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_x(op_x),
        .sq_valid(sq_valid), .sq_out(sq_out)
    );

    int checks = 0;
    int fails  = 0;
    bit              hv [3];
    logic [OP_W-1:0] hx [3];
    string           ht [3];
    logic [OUT_W-1:0] last_sq;

    function automatic logic [OUT_W-1:0] ref_sq(logic [OP_W-1:0] x);
        return OUT_W'(x) * OUT_W'(x);
    endfunction

    function automatic logic [OP_W-1:0] rnd_op();
        logic [63:0] r;
        r = {$urandom, $urandom};
        case ($urandom % 4)
            0: return OP_W'(64'd1 << ($urandom % OP_W));
            1: return ~OP_W'(64'd1 << ($urandom % OP_W));
            default: return r[OP_W-1:0];
        endcase
    endfunction

    task automatic chk(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hx[i] = '0; ht[i] = "";
        end
        last_sq = '0;
    endtask

    task automatic observe();
        if (hv[2]) begin
            chk({ht[2], " valid flag"}, OUT_W'(sq_valid), OUT_W'(1));
            chk(ht[2], sq_out, ref_sq(hx[2]));
            last_sq = ref_sq(hx[2]);
        end else begin
            chk("R3 idle valid low", OUT_W'(sq_valid), OUT_W'(0));
            chk("R5 output held", sq_out, last_sq);
        end
    endtask

    task automatic step(bit v, logic [OP_W-1:0] x, string tag);
        @(negedge clk);
        observe();
        hv[2] = hv[1]; hx[2] = hx[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hx[1] = hx[0]; ht[1] = ht[0];
        hv[0] = v;     hx[0] = x;     ht[0] = tag;
        op_valid = v;
        op_x     = v ? x : rnd_op();
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            op_valid = 1'b1;
            op_x     = rnd_op();
            @(negedge clk);
        end
        // R6: outputs cleared by reset
        chk("R6 reset valid", OUT_W'(sq_valid), OUT_W'(0));
        chk("R6 reset value", sq_out, '0);
        rst      = 1'b0;
        op_valid = 1'b0;
        op_x     = '0;
        clear_hist();
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17c3e1));
        rst = 1'b1; op_valid = 1'b0; op_x = '0;
        clear_hist();
        do_reset(5);

        // R7 extremes
        step(1, '0, "R7 zero");
        step(1, '1, "R7 all ones");
        step(1, OP_W'(64'd1 << 32), "R7 top bit only");
        step(0, '0, "");
        // R1 slice boundaries
        step(1, OP_W'(17'h1FFFF), "R1 low slice only");
        step(1, OP_W'(64'h1FFFE0000), "R1 upper slice only");
        step(1, OP_W'(64'd1 << 16), "R1 bit 16");
        step(1, OP_W'(64'd1 << 17), "R1 bit 17");
        // R8 cross term placement
        step(1, OP_W'((64'd1 << 17) + 1), "R8 2^17+1");
        step(1, OP_W'(64'h1FFFF_FFFF), "R8 dense carries");
        step(0, '0, "");
        step(0, '0, "");
        step(0, '0, "");
        step(0, '0, "");
        // R4 back-to-back stream
        for (int i = 0; i < 40; i++) step(1, rnd_op(), "R4 back-to-back");

        // reset with operands in flight
        step(1, rnd_op(), "R6 in flight");
        step(1, rnd_op(), "R6 in flight");
        do_reset(2);
        step(0, '0, "");
        step(0, '0, "");
        step(0, '0, "");

        // R2 / R5 random mix with gaps
        for (int i = 0; i < 1500; i++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, rnd_op(), "R2 random");
        end
        for (int i = 0; i < 4; i++) step(0, '0, "");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule